// File: doc/BRIEF.md
# Beam-Scan Chirp Sequencer

This controller paces a radar front end through a fixed repeating pass. A pass starts with a long chirp and its listen window. A guard gap follows, then a short chirp and its listen window, then a single bookkeeping cycle that advances the scan position. Every timed phase takes its length in clock cycles from a run-time input, so the pass timing can be retuned without rebuilding. Three nested counters track the scan position: chirp within elevation, elevation within azimuth, and azimuth within scan. The number of chirps per elevation is a run-time input. The elevation and azimuth counts are build parameters.

A 2-bit mode input selects how the sequencer runs:
- Host mode (00) holds the sequencer idle and relays external chirp, elevation and azimuth requests to the indication outputs.
- Continuous scan (01) runs passes back to back.
- Single-chirp mode (10) runs only the long chirp and long listen, once per trigger.
- Triggered pass mode (11) runs one complete pass per trigger.

The current state and phase timer are brought out for observation.

Top module: `beam_scan_ctrl`

## Requirements
- R1: `state_o` uses the encoding idle=0, long chirp=1, long listen=2, guard=3, short chirp=4, short listen=5, advance=6. The value 7 never appears. `scanning_o` is 1 exactly when `state_o` is not 0.
- R2: Each timed state (1 to 5) lasts max(len,1) cycles, where len is its length input. `timer_o` reads 0,1,... within the phase and never reaches len. The advance state lasts one cycle. `timer_o` is 0 outside the timed states.
- R3: `long_sel_o` is 1 in states 1 and 2, and 0 in every other state.
- R4: Each advance cycle adds one to the chirp count, which wraps to 0 at max(`chirps_per_elev_i`,1). A chirp wrap adds one to the elevation count, which wraps at ELEVS_PER_AZ. An elevation wrap adds one to the azimuth count, which wraps at AZS_PER_SCAN. In modes 01 and 11, `new_elev_o` and `new_az_o` are one-cycle pulses in the cycle after the chirp wrap and the elevation wrap respectively.
- R5: `scan_done_o` pulses for one cycle in the cycle after the azimuth count wraps, and all three counts read 0 in that cycle. In continuous scan the pulses are P·max(cpe,1)·ELEVS_PER_AZ·AZS_PER_SCAN cycles apart, where P is the sum of the five phase lengths (each taken as at least 1) plus 1.
- R6: In mode 01, idle moves to long chirp on the next clock, and advance is followed by long chirp. `new_chirp_o` is 1 in exactly the first cycle of each long chirp.
- R7: In mode 10, `trigger_i` high in idle starts a long chirp. When the long-listen timer expires, the sequencer returns to idle, and the counters are left unchanged.
- R8: In mode 11, `trigger_i` high in idle runs one full pass through advance, then the sequencer returns to idle with the counters advanced by one step.
- R9: In mode 00, the next state is idle from any state, and `new_chirp_o`, `new_elev_o` and `new_az_o` equal `ext_chirp_i`, `ext_elev_i` and `ext_az_i` delayed by one cycle. In the other modes the external request inputs are ignored. `trigger_i` is ignored in modes 00 and 01.
- R10: `rst_ni` low resets the block asynchronously. It forces state 0, timer 0, all counts 0 and all pulse outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 host, 01 continuous, 10 single chirp, 11 triggered pass |
| ext_chirp_i | input | 1 | External chirp request (host mode) |
| ext_elev_i | input | 1 | External elevation request (host mode) |
| ext_az_i | input | 1 | External azimuth request (host mode) |
| trigger_i | input | 1 | Start request for modes 10 and 11 |
| long_chirp_len_i | input | TIMER_W | Long chirp length, cycles |
| long_listen_len_i | input | TIMER_W | Long listen length, cycles |
| guard_len_i | input | TIMER_W | Guard length, cycles |
| short_chirp_len_i | input | TIMER_W | Short chirp length, cycles |
| short_listen_len_i | input | TIMER_W | Short listen length, cycles |
| chirps_per_elev_i | input | CNT_W | Chirps per elevation |
| long_sel_o | output | 1 | Long waveform selected |
| new_chirp_o | output | 1 | Chirp start indication |
| new_elev_o | output | 1 | Elevation step indication |
| new_az_o | output | 1 | Azimuth step indication |
| chirp_cnt_o | output | CNT_W | Chirp count |
| elev_cnt_o | output | CNT_W | Elevation count |
| az_cnt_o | output | CNT_W | Azimuth count |
| scanning_o | output | 1 | Not idle |
| scan_done_o | output | 1 | Full scan finished |
| state_o | output | 3 | Current state |
| timer_o | output | TIMER_W | Phase timer |

## Verification
The bench builds the block with ELEVS_PER_AZ=2 and AZS_PER_SCAN=3. With those values and phase lengths of 0, 1 or 3 cycles, one complete scan takes at most a few hundred cycles. This makes it possible to walk every cycle of a full scan, including every counter wrap and the scan-done pulse, for all 243 combinations of phase lengths. A second sweep varies chirps per elevation from 0 to 4, so the zero-length and one-chirp wrap cases are covered. The single-chirp mode, the triggered-pass mode, the host mode, an abort to host mode, and an asynchronous reset are each run against short expected timelines.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LCHIRP  = 3'd1,
    ST_LLISTEN = 3'd2,
    ST_GUARD   = 3'd3,
    ST_SCHIRP  = 3'd4,
    ST_SLISTEN = 3'd5,
    ST_ADV     = 3'd6
  } scan_st_e;

  typedef enum logic [1:0] {
    MD_HOST   = 2'd0,
    MD_AUTO   = 2'd1,
    MD_SINGLE = 2'd2,
    MD_TRIG   = 2'd3
  } scan_md_e;
endpackage

// File: rtl/bsc_phase_timer.sv
module bsc_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         zero_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] timer_o,
  output logic         last_o
);
  logic [W-1:0] timer_q;
  logic [W:0]   nxt;

  // widened compare: len 0 behaves as len 1
  assign nxt    = {1'b0, timer_q} + {{W{1'b0}}, 1'b1};
  assign last_o = nxt >= {1'b0, len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     timer_q <= '0;
    else if (zero_i) timer_q <= '0;
    else             timer_q <= timer_q + W'(1);
  end

  assign timer_o = timer_q;

  a_r2_zero_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> timer_q == '0);
endmodule

// File: rtl/bsc_wrap_counter.sv
module bsc_wrap_counter #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt    = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign wrap_o = step_i && (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/beam_scan_ctrl.sv
module beam_scan_ctrl
  import bsc_pkg::*;
#(
  parameter int TIMER_W      = 16,
  parameter int CNT_W        = 6,
  parameter int ELEVS_PER_AZ = 8,
  parameter int AZS_PER_SCAN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic               ext_chirp_i,
  input  logic               ext_elev_i,
  input  logic               ext_az_i,
  input  logic               trigger_i,
  input  logic [TIMER_W-1:0] long_chirp_len_i,
  input  logic [TIMER_W-1:0] long_listen_len_i,
  input  logic [TIMER_W-1:0] guard_len_i,
  input  logic [TIMER_W-1:0] short_chirp_len_i,
  input  logic [TIMER_W-1:0] short_listen_len_i,
  input  logic [CNT_W-1:0]   chirps_per_elev_i,
  output logic               long_sel_o,
  output logic               new_chirp_o,
  output logic               new_elev_o,
  output logic               new_az_o,
  output logic [CNT_W-1:0]   chirp_cnt_o,
  output logic [CNT_W-1:0]   elev_cnt_o,
  output logic [CNT_W-1:0]   az_cnt_o,
  output logic               scanning_o,
  output logic               scan_done_o,
  output logic [2:0]         state_o,
  output logic [TIMER_W-1:0] timer_o
);
  localparam logic [CNT_W-1:0] ELEV_LIM = CNT_W'(ELEVS_PER_AZ);
  localparam logic [CNT_W-1:0] AZ_LIM   = CNT_W'(AZS_PER_SCAN);

  scan_st_e           state_q, state_n;
  scan_md_e           mode;
  logic               timed_q, last, zero, step;
  logic [TIMER_W-1:0] len_sel;
  logic               chirp_wrap, elev_wrap, az_wrap;
  logic               new_chirp_q, new_elev_q, new_az_q, done_q;

  assign mode    = scan_md_e'(mode_i);
  assign timed_q = state_q inside {ST_LCHIRP, ST_LLISTEN, ST_GUARD, ST_SCHIRP, ST_SLISTEN};

  always_comb begin
    unique case (state_q)
      ST_LCHIRP:  len_sel = long_chirp_len_i;
      ST_LLISTEN: len_sel = long_listen_len_i;
      ST_GUARD:   len_sel = guard_len_i;
      ST_SCHIRP:  len_sel = short_chirp_len_i;
      ST_SLISTEN: len_sel = short_listen_len_i;
      default:    len_sel = '0;
    endcase
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (mode == MD_AUTO) state_n = ST_LCHIRP;
        else if ((mode == MD_SINGLE || mode == MD_TRIG) && trigger_i) state_n = ST_LCHIRP;
      end
      ST_LCHIRP:  if (last) state_n = ST_LLISTEN;
      ST_LLISTEN: if (last) state_n = (mode == MD_SINGLE) ? ST_IDLE : ST_GUARD;
      ST_GUARD:   if (last) state_n = ST_SCHIRP;
      ST_SCHIRP:  if (last) state_n = ST_SLISTEN;
      ST_SLISTEN: if (last) state_n = ST_ADV;
      ST_ADV:     state_n = (mode == MD_AUTO) ? ST_LCHIRP : ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
    if (mode == MD_HOST) state_n = ST_IDLE;
  end

  // timer restarts on every state change and rests at 0 outside timed phases
  assign zero = (state_n != state_q) || !timed_q;
  assign step = state_q == ST_ADV;

  bsc_phase_timer #(.W(TIMER_W)) u_timer (
    .clk_i, .rst_ni, .zero_i(zero), .len_i(len_sel), .timer_o, .last_o(last)
  );

  bsc_wrap_counter #(.W(CNT_W)) u_chirp (
    .clk_i, .rst_ni, .step_i(step), .limit_i(chirps_per_elev_i),
    .cnt_o(chirp_cnt_o), .wrap_o(chirp_wrap)
  );
  bsc_wrap_counter #(.W(CNT_W)) u_elev (
    .clk_i, .rst_ni, .step_i(chirp_wrap), .limit_i(ELEV_LIM),
    .cnt_o(elev_cnt_o), .wrap_o(elev_wrap)
  );
  bsc_wrap_counter #(.W(CNT_W)) u_az (
    .clk_i, .rst_ni, .step_i(elev_wrap), .limit_i(AZ_LIM),
    .cnt_o(az_cnt_o), .wrap_o(az_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      new_chirp_q <= 1'b0;
      new_elev_q  <= 1'b0;
      new_az_q    <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= az_wrap;
      if (mode == MD_HOST) begin
        new_chirp_q <= ext_chirp_i;
        new_elev_q  <= ext_elev_i;
        new_az_q    <= ext_az_i;
      end else begin
        new_chirp_q <= (state_n == ST_LCHIRP) && (state_q != ST_LCHIRP);
        new_elev_q  <= chirp_wrap;
        new_az_q    <= elev_wrap;
      end
    end
  end

  assign state_o     = state_q;
  assign long_sel_o  = (state_q == ST_LCHIRP) || (state_q == ST_LLISTEN);
  assign scanning_o  = state_q != ST_IDLE;
  assign new_chirp_o = new_chirp_q;
  assign new_elev_o  = new_elev_q;
  assign new_az_o    = new_az_q;
  assign scan_done_o = done_q;

  a_r1_no_code7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'd7);
  a_r2_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timed_q && len_sel != '0 && $stable(len_sel)) |-> timer_o < len_sel);
  a_r3_chirp_is_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_chirp_o && mode != MD_HOST && $past(mode) != MD_HOST) |-> long_sel_o);
  a_r4_elev_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elev_cnt_o < ELEV_LIM);
  a_r4_az_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    az_cnt_o < AZ_LIM);
  a_r5_done_at_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |-> (chirp_cnt_o == '0 && elev_cnt_o == '0 && az_cnt_o == '0));
  a_r6_auto_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_AUTO && state_q == ST_IDLE) |=> state_o == 3'd1);
  a_r7_single_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MD_SINGLE && state_q == ST_LLISTEN && last) |=> state_o == 3'd0);
  a_r9_host_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MD_HOST |=> state_o == 3'd0);
  a_r9_host_relay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MD_HOST |=> new_chirp_o == $past(ext_chirp_i));
endmodule

// File: tb/beam_scan_ctrl_tb.sv
`timescale 1ns/1ps
module beam_scan_ctrl_tb;
  localparam int TW = 16;
  localparam int CW = 6;
  localparam int NE = 2;
  localparam int NA = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic ext_c = 0, ext_e = 0, ext_a = 0, trig = 0;
  logic [TW-1:0] l_lc = 1, l_ll = 1, l_g = 1, l_sc = 1, l_sl = 1;
  logic [CW-1:0] cpe = 2;
  logic long_sel, nc, ne, na, done, scanning;
  logic [CW-1:0] c_cnt, e_cnt, a_cnt;
  logic [2:0] st;
  logic [TW-1:0] tmr;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  beam_scan_ctrl #(.TIMER_W(TW), .CNT_W(CW), .ELEVS_PER_AZ(NE), .AZS_PER_SCAN(NA)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .ext_chirp_i(ext_c), .ext_elev_i(ext_e), .ext_az_i(ext_a), .trigger_i(trig),
    .long_chirp_len_i(l_lc), .long_listen_len_i(l_ll), .guard_len_i(l_g),
    .short_chirp_len_i(l_sc), .short_listen_len_i(l_sl), .chirps_per_elev_i(cpe),
    .long_sel_o(long_sel), .new_chirp_o(nc), .new_elev_o(ne), .new_az_o(na),
    .chirp_cnt_o(c_cnt), .elev_cnt_o(e_cnt), .az_cnt_o(a_cnt),
    .scanning_o(scanning), .scan_done_o(done), .state_o(st), .timer_o(tmr)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int pass_len();
    return eff(int'(l_lc)) + eff(int'(l_ll)) + eff(int'(l_g)) + eff(int'(l_sc)) + eff(int'(l_sl)) + 1;
  endfunction

  // expected state and timer at a position inside one pass
  task automatic exp_at(input int pos, output int es, output int et);
    int e[5];
    int acc;
    e[0] = eff(int'(l_lc)); e[1] = eff(int'(l_ll)); e[2] = eff(int'(l_g));
    e[3] = eff(int'(l_sc)); e[4] = eff(int'(l_sl));
    acc = 0; es = 6; et = 0;
    for (int i = 0; i < 5; i++) begin
      if (es == 6 && pos < acc + e[i]) begin es = i + 1; et = pos - acc; end
      acc += e[i];
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  // continuous scan from reset release: sample n taken after the (n+1)th edge
  task automatic run_auto(input int nsamp);
    int p, ce, pos, pss, es, et;
    p = pass_len(); ce = eff(int'(cpe));
    for (int n = 0; n < nsamp; n++) begin
      @(negedge clk);
      pos = n % p; pss = n / p;
      exp_at(pos, es, et);
      check("R2 state", int'(st), es);
      check("R2 timer", int'(tmr), et);
      check("R1 scanning", int'(scanning), 1);
      check("R3 long_sel", int'(long_sel), (es == 1 || es == 2) ? 1 : 0);
      check("R4 chirp_cnt", int'(c_cnt), pss % ce);
      check("R4 elev_cnt", int'(e_cnt), (pss / ce) % NE);
      check("R4 az_cnt", int'(a_cnt), (pss / (ce * NE)) % NA);
      check("R6 new_chirp", int'(nc), (pos == 0) ? 1 : 0);
      // ext inputs may be high here: R9 requires them ignored
      check("R4 new_elev", int'(ne), (pos == 0 && pss > 0 && pss % ce == 0) ? 1 : 0);
      check("R4 new_az", int'(na), (pos == 0 && pss > 0 && pss % (ce * NE) == 0) ? 1 : 0);
      check("R5 scan_done", int'(done), (pos == 0 && pss > 0 && pss % (ce * NE * NA) == 0) ? 1 : 0);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int vals[3];
    int idx, p, es, et;
    vals[0] = 0; vals[1] = 1; vals[2] = 3;

    // R10 reset state, R1 idle encoding
    mode = 2'd1;
    #1;
    check("R10 reset state", int'(st), 0);
    check("R10 reset timer", int'(tmr), 0);
    check("R10 reset counts", int'(c_cnt) + int'(e_cnt) + int'(a_cnt), 0);
    check("R10 reset pulses", int'(nc) + int'(ne) + int'(na) + int'(done), 0);
    check("R1 idle not scanning", int'(scanning), 0);

    // R2..R6 sweep of phase lengths
    idx = 0;
    cpe = 2;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++)
            for (int f = 0; f < 3; f++) begin
              l_lc = TW'(vals[a]); l_ll = TW'(vals[b]); l_g = TW'(vals[c]);
              l_sc = TW'(vals[d]); l_sl = TW'(vals[f]);
              ext_c = idx[0]; ext_e = idx[0]; ext_a = idx[0]; trig = idx[1];
              mode = 2'd1;
              do_reset();
              p = pass_len();
              run_auto(p * 2 * NE * NA + p + 2);
              idx++;
            end

    // R4 R5 chirps-per-elevation sweep including 0
    l_lc = 1; l_ll = 2; l_g = 1; l_sc = 2; l_sl = 1;
    ext_c = 0; ext_e = 0; ext_a = 0; trig = 0;
    for (int k = 0; k < 5; k++) begin
      cpe = CW'(k);
      do_reset();
      p = pass_len();
      run_auto(p * eff(k) * NE * NA * 2 + 3);
    end

    // R7 single chirp
    cpe = 2; l_lc = 3; l_ll = 2; l_g = 1; l_sc = 1; l_sl = 1;
    mode = 2'd2;
    do_reset();
    for (int rep = 0; rep < 2; rep++) begin
      for (int n = 0; n < 3; n++) begin
        @(negedge clk);
        check("R7 waits idle", int'(st), 0);
      end
      trig = 1'b1;
      for (int n = 0; n < 7; n++) begin
        @(negedge clk);
        trig = 1'b0;
        if (n < 5) begin
          exp_at(n, es, et);
          check("R7 state", int'(st), es);
          check("R7 timer", int'(tmr), et);
        end else begin
          check("R7 back to idle", int'(st), 0);
        end
        check("R7 new_chirp", int'(nc), (n == 0) ? 1 : 0);
        check("R7 counts unchanged", int'(c_cnt) + int'(e_cnt) + int'(a_cnt), 0);
      end
    end

    // R8 triggered pass
    mode = 2'd3;
    do_reset();
    p = pass_len();
    for (int rep = 0; rep < 2; rep++) begin
      @(negedge clk);
      check("R8 waits idle", int'(st), 0);
      trig = 1'b1;
      for (int n = 0; n <= p; n++) begin
        @(negedge clk);
        trig = 1'b0;
        if (n < p) begin
          exp_at(n, es, et);
          check("R8 state", int'(st), es);
          check("R8 count held", int'(c_cnt), rep);
        end else begin
          check("R8 idle after pass", int'(st), 0);
          check("R8 chirp_cnt", int'(c_cnt), (rep + 1) % 2);
          check("R8 elev_cnt", int'(e_cnt), (rep == 1) ? 1 : 0);
          check("R8 new_elev", int'(ne), (rep == 1) ? 1 : 0);
        end
      end
    end

    // R9 host relay, trigger ignored
    mode = 2'd0;
    do_reset();
    for (int pat = 0; pat < 8; pat++) begin
      ext_c = pat[0]; ext_e = pat[1]; ext_a = pat[2]; trig = 1'b1;
      @(negedge clk);
      check("R9 relay chirp", int'(nc), pat & 1);
      check("R9 relay elev", int'(ne), (pat >> 1) & 1);
      check("R9 relay az", int'(na), (pat >> 2) & 1);
      check("R9 host idle", int'(st), 0);
      check("R1 host not scanning", int'(scanning), 0);
    end
    trig = 1'b0; ext_c = 0; ext_e = 0; ext_a = 0;

    // R9 abort to host mode mid-phase
    l_lc = 3; l_ll = 3; l_g = 3; l_sc = 3; l_sl = 3;
    mode = 2'd1;
    do_reset();
    for (int n = 0; n < 8; n++) @(negedge clk);
    check("R9 running before abort", int'(st), 3);
    mode = 2'd0;
    @(negedge clk);
    check("R9 abort state", int'(st), 0);
    check("R9 abort timer", int'(tmr), 0);

    // R10 asynchronous reset mid-scan
    l_lc = 1; l_ll = 1; l_g = 1; l_sc = 1; l_sl = 1; cpe = 2;
    mode = 2'd1;
    do_reset();
    for (int n = 0; n < 40; n++) @(negedge clk);
    check("R10 counts moved", (int'(c_cnt) + int'(e_cnt) + int'(a_cnt)) > 0 ? 1 : 0, 1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R10 async state", int'(st), 0);
    check("R10 async timer", int'(tmr), 0);
    check("R10 async counts", int'(c_cnt) + int'(e_cnt) + int'(a_cnt), 0);
    check("R10 async pulses", int'(nc) + int'(ne) + int'(na) + int'(done), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule